// File: doc/BRIEF.md
# Three-Phase Bridge Gate-Drive Logic

This block is the digital control core of a three-phase half-bridge gate driver. Each phase has a low-side command and an active-low high-side command. Per phase, the block produces a registered low-side gate enable and a registered high-side gate enable. It resolves the two commands of a phase by a fixed priority. It forces all gates off while a global disable or an undervoltage flag is active. It delays every gate turn-on by a programmable dead time, but it removes a gate at once.

Each time the bridge becomes enabled (leaving reset, disable falling, undervoltage clearing), the block first issues a bootstrap refresh pulse. During the pulse every low-side gate is on and every high-side gate is off. Normal command-driven operation starts when the pulse ends. All inputs except the two count settings pass through a two-flop synchronizer. The dead-time and refresh-length settings are static counts of the system clock.

Top module: `bridge_gate_ctrl`

## Requirements
- R1: While the synchronized disable input is high, all six gate outputs are low, whatever the commands are. Gates fall on the third rising edge after disable is driven high.
- R2: While the synchronized undervoltage flag is high, all six gate outputs are low, with the same three-edge latency as R1.
- R3: The high-side command is active-low. In normal operation with the low-side command 0, a high-side command of 0 turns that phase's high-side gate on and a 1 turns it off.
- R4: With dead time in force (bypass low and dt_count nonzero), a low-side command of 1 turns the low-side gate on and holds that phase's high-side gate off, whatever the high-side command is.
- R5: When dt_bypass is high or dt_count is 0, each gate follows its own command with no dead time. Low command 1 with high command 0 then turns both gates of the phase on.
- R6: A gate whose request drops goes low on the third rising edge after the command change. A gate turn-on is delayed by dt_count further edges, so it appears on edge 3 + dt_count.
- R7: After reset release, disable falling or undervoltage clearing, all low-side gates are high and all high-side gates are low for max(rf_count,1) cycles when dead time is zero. Command-driven operation follows.
- R8: Disable or undervoltage arriving during a refresh pulse ends the pulse at once. Re-enabling then starts a complete new pulse of the full length.
- R9: Each of the six gates times its own turn-on. A request withdrawn before its dead time expires never produces a gate pulse.
- R10: Both gates of a phase are high together only when no-dead-time operation (R5) was selected in the previous cycle.
- R11: During reset, all gate outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lo_cmd | input | NPH | Low-side command per phase, active high |
| hi_cmd_n | input | NPH | High-side command per phase, active low |
| dis_in | input | 1 | Global disable, active high |
| uv_flag | input | 1 | Undervoltage flag from comparator, active high |
| dt_bypass | input | 1 | High removes dead time and priority |
| dt_count | input | CW | Dead time in clock cycles |
| rf_count | input | RW | Refresh pulse length in clock cycles |
| lo_gate | output | NPH | Registered low-side gate enables |
| hi_gate | output | NPH | Registered high-side gate enables |

## Verification
The bench builds the block with its defaults: three phases and 8-bit dead-time and refresh counters. It programs dead times of 0 to 5 cycles and refresh lengths of 0 to 20 cycles. With these short windows, expiry, cancellation before expiry, and aborts in the middle of a pulse all happen within a few cycles. It also sets a refresh length of 0 to exercise the one-cycle minimum pulse. A cycle model in the bench, written from the requirements, predicts every gate. Directed cases measure exact latencies and pulse widths.

// File: rtl/bgc_pkg.sv
package bgc_pkg;
  typedef enum logic [1:0] {
    MODE_OFF     = 2'd0,
    MODE_REFRESH = 2'd1,
    MODE_RUN     = 2'd2
  } mode_t;
endpackage

// File: rtl/bgc_sync.sv
module bgc_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= RST_VAL;
      stage2 <= RST_VAL;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/bgc_refresh.sv
module bgc_refresh
  import bgc_pkg::*;
#(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          blocked,
  input  logic [RW-1:0] rf_len,
  output mode_t         mode
);
  logic [RW-1:0] cnt;
  logic [RW:0]   cnt_inc;
  logic          last;

  assign cnt_inc = {1'b0, cnt} + (RW+1)'(1);
  assign last    = cnt_inc >= {1'b0, rf_len};

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= MODE_OFF;
      cnt  <= '0;
    end else if (blocked) begin
      mode <= MODE_OFF;
      cnt  <= '0;
    end else begin
      unique case (mode)
        MODE_OFF: begin
          mode <= MODE_REFRESH;
          cnt  <= '0;
        end
        MODE_REFRESH: begin
          if (last) mode <= MODE_RUN;
          else      cnt  <= cnt_inc[RW-1:0];
        end
        default: mode <= MODE_RUN;
      endcase
    end
  end

  // R1
  blocked_to_off_chk: assert property (@(posedge clk) disable iff (rst)
    blocked |=> (mode == MODE_OFF));

  // R8
  refresh_after_off_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_REFRESH) |-> $past(mode != MODE_RUN));
endmodule

// File: rtl/bgc_ontimer.sv
module bgc_ontimer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          no_delay,
  input  logic [CW-1:0] dt_len,
  output logic          gate
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate <= 1'b0;
      cnt  <= '0;
    end else if (!req) begin
      gate <= 1'b0;
      cnt  <= '0;
    end else if (!gate) begin
      if (no_delay || cnt >= dt_len) gate <= 1'b1;
      else                           cnt  <= cnt + 1'b1;
    end
  end

  // R6
  off_prompt_chk: assert property (@(posedge clk) disable iff (rst)
    !req |=> !gate);

  // R9
  rise_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate) |-> $past(req));
endmodule

// File: rtl/bridge_gate_ctrl.sv
module bridge_gate_ctrl
  import bgc_pkg::*;
#(
  parameter int NPH = 3,
  parameter int CW  = 8,
  parameter int RW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NPH-1:0] lo_cmd,
  input  logic [NPH-1:0] hi_cmd_n,
  input  logic           dis_in,
  input  logic           uv_flag,
  input  logic           dt_bypass,
  input  logic [CW-1:0]  dt_count,
  input  logic [RW-1:0]  rf_count,
  output logic [NPH-1:0] lo_gate,
  output logic [NPH-1:0] hi_gate
);
  localparam int SW = 3 + 2*NPH;
  localparam logic [SW-1:0] SYNC_RST = {1'b1, 1'b1, 1'b0, {NPH{1'b0}}, {NPH{1'b1}}};

  logic [SW-1:0]  sync_q;
  logic           dis_s, uv_s, byp_s, blocked, no_delay;
  logic [NPH-1:0] lo_s, hin_s, lo_req, hi_req;
  mode_t          mode;

  bgc_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({dis_in, uv_flag, dt_bypass, lo_cmd, hi_cmd_n}),
    .q   (sync_q)
  );

  assign dis_s    = sync_q[SW-1];
  assign uv_s     = sync_q[SW-2];
  assign byp_s    = sync_q[SW-3];
  assign lo_s     = sync_q[2*NPH-1:NPH];
  assign hin_s    = sync_q[NPH-1:0];
  assign blocked  = dis_s | uv_s;
  assign no_delay = byp_s | (dt_count == '0);

  bgc_refresh #(.RW(RW)) u_refresh (
    .clk     (clk),
    .rst     (rst),
    .blocked (blocked),
    .rf_len  (rf_count),
    .mode    (mode)
  );

  for (genvar i = 0; i < NPH; i++) begin : g_phase
    always_comb begin
      lo_req[i] = 1'b0;
      hi_req[i] = 1'b0;
      if (!blocked) begin
        unique case (mode)
          MODE_REFRESH: lo_req[i] = 1'b1;
          MODE_RUN: begin
            lo_req[i] = lo_s[i];
            hi_req[i] = !hin_s[i] && (no_delay || !lo_s[i]);
          end
          default: ;
        endcase
      end
    end

    bgc_ontimer #(.CW(CW)) u_lo (
      .clk      (clk),
      .rst      (rst),
      .req      (lo_req[i]),
      .no_delay (no_delay),
      .dt_len   (dt_count),
      .gate     (lo_gate[i])
    );

    bgc_ontimer #(.CW(CW)) u_hi (
      .clk      (clk),
      .rst      (rst),
      .req      (hi_req[i]),
      .no_delay (no_delay),
      .dt_len   (dt_count),
      .gate     (hi_gate[i])
    );
  end

  // R1
  blocked_gates_off_chk: assert property (@(posedge clk) disable iff (rst)
    blocked |=> ((lo_gate | hi_gate) == '0));

  // R7
  refresh_high_off_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_REFRESH) |=> (hi_gate == '0));

  // R10
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    ((lo_gate & hi_gate) != '0) |-> $past(no_delay));
endmodule

// File: tb/bridge_gate_ctrl_test.sv
`timescale 1ns/1ps
module bridge_gate_ctrl_test;
  localparam int NPH = 3;
  localparam int CW  = 8;
  localparam int RW  = 8;
  localparam int W   = 3 + 2*NPH;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NPH-1:0] lo_cmd = '0, hi_cmd_n = '1;
  logic dis = 1'b1, uv = 1'b0, byp = 1'b0;
  logic [CW-1:0] dt = '0;
  logic [RW-1:0] rf = 8'd3;
  logic [NPH-1:0] lo_gate, hi_gate;

  int compared = 0, mismatched = 0;
  string cur_req = "R11";

  always #4 clk = ~clk;

  bridge_gate_ctrl #(.NPH(NPH), .CW(CW), .RW(RW)) uut (
    .clk(clk), .rst(rst), .lo_cmd(lo_cmd), .hi_cmd_n(hi_cmd_n),
    .dis_in(dis), .uv_flag(uv), .dt_bypass(byp), .dt_count(dt),
    .rf_count(rf), .lo_gate(lo_gate), .hi_gate(hi_gate)
  );

  // Cycle model built from the requirements
  logic [W-1:0] m1, m2;
  int mmode, mrc;
  int mcl[NPH], mch[NPH];
  logic [NPH-1:0] mlo, mhi;

  always @(posedge clk) begin
    logic blk, nd, rl, rh;
    if (rst) begin
      m1 <= {2'b11, 1'b0, {NPH{1'b0}}, {NPH{1'b1}}};
      m2 <= {2'b11, 1'b0, {NPH{1'b0}}, {NPH{1'b1}}};
      mmode <= 0; mrc <= 0; mlo <= '0; mhi <= '0;
      for (int i = 0; i < NPH; i++) begin mcl[i] <= 0; mch[i] <= 0; end
    end else begin
      m1 <= {dis, uv, byp, lo_cmd, hi_cmd_n};
      m2 <= m1;
      blk = m2[W-1] | m2[W-2];
      nd  = m2[W-3] | (dt == 0);
      for (int i = 0; i < NPH; i++) begin
        rl = 0; rh = 0;
        if (!blk && mmode == 1) rl = 1;
        if (!blk && mmode == 2) begin
          rl = m2[NPH+i];
          rh = !m2[i] && (nd || !m2[NPH+i]);
        end
        if (!rl) begin mlo[i] <= 0; mcl[i] <= 0; end
        else if (!mlo[i]) begin
          if (nd || mcl[i] >= int'(dt)) mlo[i] <= 1; else mcl[i] <= mcl[i] + 1;
        end
        if (!rh) begin mhi[i] <= 0; mch[i] <= 0; end
        else if (!mhi[i]) begin
          if (nd || mch[i] >= int'(dt)) mhi[i] <= 1; else mch[i] <= mch[i] + 1;
        end
      end
      if (blk) begin mmode <= 0; mrc <= 0; end
      else if (mmode == 0) begin mmode <= 1; mrc <= 0; end
      else if (mmode == 1) begin
        if (mrc + 1 >= int'(rf)) mmode <= 2; else mrc <= mrc + 1;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk({cur_req, " lo_gate"}, int'(lo_gate), int'(mlo));
      chk({cur_req, " hi_gate"}, int'(hi_gate), int'(mhi));
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_refresh(int win, output int n);
    n = 0;
    for (int k = 0; k < win; k++) begin
      @(negedge clk);
      if (lo_gate == '1 && hi_gate == '0) n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd4711));
    step(5);
    // R11 reset state
    chk("R11 reset lo", int'(lo_gate), 0);
    chk("R11 reset hi", int'(hi_gate), 0);
    rst = 1'b0;

    // R1 disable overrides commands
    cur_req = "R1";
    lo_cmd = '1; hi_cmd_n = '0;
    step(10);
    chk("R1 disabled gates", int'(lo_gate | hi_gate), 0);

    // R7 refresh on disable fall, zero dead time
    cur_req = "R7";
    lo_cmd = '0; hi_cmd_n = '1; rf = 8'd5;
    dis = 1'b0;
    count_refresh(30, n);
    chk("R7 refresh width 5", n, 5);

    // R3 inverted high-side command
    cur_req = "R3";
    hi_cmd_n = 3'b110;
    step(4);
    chk("R3 hi on for cmd 0", int'(hi_gate), 1);
    hi_cmd_n = 3'b111;
    step(4);
    chk("R3 hi off for cmd 1", int'(hi_gate), 0);

    // R4 low-side priority with dead time
    cur_req = "R4";
    dt = 8'd2; lo_cmd = 3'b010; hi_cmd_n = 3'b000;
    step(10);
    chk("R4 lo", int'(lo_gate), 2);
    chk("R4 hi", int'(hi_gate), 5);

    // R6 turn-on delay and prompt turn-off
    cur_req = "R6";
    dt = 8'd4; lo_cmd = '0; hi_cmd_n = '1;
    step(10);
    lo_cmd[2] = 1'b1;
    n = 0;
    while (!lo_gate[2] && n < 30) begin @(negedge clk); n++; end
    chk("R6 turn-on edges", n, 7);
    lo_cmd[2] = 1'b0;
    n = 0;
    while (lo_gate[2] && n < 30) begin @(negedge clk); n++; end
    chk("R6 turn-off edges", n, 3);

    // R9 withdrawn request cancels
    cur_req = "R9";
    step(4);
    lo_cmd[1] = 1'b1;
    step(2);
    lo_cmd[1] = 1'b0;
    n = 0;
    for (int k = 0; k < 12; k++) begin @(negedge clk); if (lo_gate[1]) n++; end
    chk("R9 no pulse", n, 0);

    // R5 bypass and zero dead time
    cur_req = "R5";
    byp = 1'b1; lo_cmd = 3'b001; hi_cmd_n = 3'b110;
    step(5);
    chk("R5 bypass lo", int'(lo_gate), 1);
    chk("R5 bypass hi", int'(hi_gate), 1);
    byp = 1'b0; dt = 8'd0;
    step(5);
    chk("R5 zero dt both", int'(lo_gate & hi_gate), 1);

    // R10 overlap removed once dead time returns
    cur_req = "R10";
    dt = 8'd3;
    step(6);
    chk("R10 overlap", int'(lo_gate & hi_gate), 0);

    // R2 undervoltage
    cur_req = "R2";
    dt = 8'd0; lo_cmd = '0; hi_cmd_n = '0;
    step(6);
    uv = 1'b1;
    step(3);
    chk("R2 uv gates", int'(lo_gate | hi_gate), 0);
    cur_req = "R7";
    uv = 1'b0;
    hi_cmd_n = '1;
    count_refresh(30, n);
    chk("R7 refresh after uv", n, 5);

    // R8 abort and full restart
    cur_req = "R8";
    rf = 8'd20;
    dis = 1'b1;
    step(6);
    dis = 1'b0;
    step(8);
    chk("R8 in refresh", int'(lo_gate), 7);
    uv = 1'b1;
    step(3);
    chk("R8 aborted", int'(lo_gate | hi_gate), 0);
    uv = 1'b0;
    count_refresh(40, n);
    chk("R8 full restart", n, 20);

    // R7 minimum length
    cur_req = "R7";
    rf = 8'd0;
    dis = 1'b1;
    step(6);
    dis = 1'b0;
    count_refresh(20, n);
    chk("R7 min width", n, 1);

    // random mix checked against model
    cur_req = "R6";
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      if ($urandom % 8 == 0) lo_cmd[$urandom % NPH] ^= 1'b1;
      if ($urandom % 8 == 0) hi_cmd_n[$urandom % NPH] ^= 1'b1;
      if ($urandom % 80 == 0) dis = ~dis;
      if ($urandom % 100 == 0) uv = ~uv;
      if ($urandom % 150 == 0) byp = ~byp;
      if ($urandom % 200 == 0) dt = CW'($urandom % 6);
      if ($urandom % 200 == 0) rf = RW'($urandom % 8);
    end
    step(2);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule